// File: doc/BRIEF.md
# Compare-FIFO PWM Timer

A 32-bit up-counter that advances on a divided version of an external tick and produces a PWM waveform, a sticky period interrupt and compare-FIFO flags. Software programs it through a narrow write port: a control word, a maximum count, a single compare value and a push port into a small compare FIFO. A command word flushes the FIFO and clears the interrupt.

There are three modes. In free-run mode the counter only wraps and raises the interrupt. In manual PWM mode the duty point comes from the compare register. In auto PWM mode a new duty point is taken from the FIFO at every wrap. This lets software queue a run of duty values ahead of time without having to meet a per-period deadline.

Top module: `cfpt_timer`

## Requirements
- R1: After synchronous reset, `cur_count` is 0, `pwm_out`, `pwm_active` and `irq` are 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Writing address 1 stores the maximum count with bit 0 forced to 0. The counter counts 0, 1, … up to that value and then returns to 0 on the next step.
- R3: Control bits [7:5] select how many tick pulses make one counter step: code 0 gives 1, 4 gives 2, 5 gives 4, 6 gives 8 and 7 gives 40, and any other code gives 1. With `tick_in` low the counter holds its value.
- R4: In manual PWM mode (control bits [2:1] = 2), `pwm_out` equals the start level while `cur_count` is below the compare register (address 2), and the opposite level otherwise. Control bit 3 set means the start level is high.
- R5: In auto PWM mode (mode 1), each wrap pops the oldest FIFO entry and uses it as the compare value from count 0 of the new period. If the FIFO is empty at wrap, the previous compare value stays in use.
- R6: Writes to address 3 push into a 4-entry FIFO. `fifo_full` is 1 while it holds 4 entries, and `fifo_empty` is 1 while it holds none. A push while full is dropped.
- R7: Writing address 4 with bit 0 set empties the FIFO on that edge.
- R8: `irq` is set on every wrap and stays set until address 4 is written with bit 1 set. A wrap on the same edge as the clear leaves it set. Stopping the counter does not clear it.
- R9: `pwm_active` is 1 only while running in a PWM mode (1 or 2) with control bit 4 (output enable) set. Whenever `pwm_active` is 0, `pwm_out` is 0, which includes free-run mode.
- R10: With control bit 0 (run) clear, the counter is held at 0 and `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 max count, 2 compare, 3 FIFO push, 4 command |
| wr_data | input | 32 | Write data |
| tick_in | input | 1 | Base tick pulse, one cycle wide per tick |
| cur_count | output | 32 | Current counter value |
| pwm_out | output | 1 | PWM waveform |
| pwm_active | output | 1 | PWM output is being driven |
| irq | output | 1 | Sticky period interrupt |
| fifo_full | output | 1 | Compare FIFO holds 4 entries |
| fifo_empty | output | 1 | Compare FIFO holds no entries |

## Verification
The hardest case to reach from the ports is an auto-mode wrap that finds the FIFO empty, after an earlier push was dropped because the FIFO was full. The stimulus fills the FIFO while the counter is stopped, pushes one more distinct value, and then starts auto mode. It measures the high time of five consecutive periods. The last period must repeat the fourth duty value, and neither the dropped value nor the old manual one may appear.

// File: rtl/cfpt_pkg.sv
package cfpt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_MANUAL = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic [2:0] div_sel;
    logic       out_en;
    logic       start_high;
    mode_e      mode;
    logic       run;
  } ctrl_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAX  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PUSH = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;
endpackage

// File: rtl/cfpt_prescaler.sv
module cfpt_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic [2:0] sel,
  output logic       step
);
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    case (sel)
      3'd4:    lim = DIV_W'(1);
      3'd5:    lim = DIV_W'(3);
      3'd6:    lim = DIV_W'(7);
      3'd7:    lim = DIV_W'(39);
      default: lim = '0;
    endcase
  end

  assign step = tick && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)      pcnt <= '0;
    else if (tick)       pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/cfpt_cmp_fifo.sv
module cfpt_cmp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = ((1 << AW) == DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_inc, rp_inc;
  logic [CW-1:0] level;
  logic          push_ok, pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  generate
    if (POW2) begin : g_nat_wrap
      assign wp_inc = wp + 1'b1;
      assign rp_inc = rp + 1'b1;
    end else begin : g_cmp_wrap
      assign wp_inc = (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      assign rp_inc = (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp_inc;
      if (pop_ok)  rp <= rp_inc;
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/cfpt_wave.sv
module cfpt_wave
  import cfpt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  mode_e        mode,
  input  logic         start_high,
  input  logic         out_en,
  input  logic [W-1:0] max_cnt,
  input  logic [W-1:0] man_cmp,
  input  logic [W-1:0] fifo_rdata,
  input  logic         fifo_empty,
  output logic         wrap_now,
  output logic         fifo_pop,
  output logic [W-1:0] cnt,
  output logic         pwm_out,
  output logic         pwm_active
);
  logic [W-1:0] act_cmp, cnt_nxt, cmp_nxt;
  logic         is_auto, is_man, on_nxt, lvl_nxt;

  assign is_auto  = (mode == MODE_AUTO);
  assign is_man   = (mode == MODE_MANUAL);
  assign wrap_now = run && step && (cnt >= max_cnt);
  assign fifo_pop = wrap_now && is_auto;

  always_comb begin
    if (!run)          cnt_nxt = '0;
    else if (wrap_now) cnt_nxt = '0;
    else if (step)     cnt_nxt = cnt + 1'b1;
    else               cnt_nxt = cnt;

    if (is_man)                     cmp_nxt = man_cmp;
    else if (fifo_pop && !fifo_empty) cmp_nxt = fifo_rdata;
    else                            cmp_nxt = act_cmp;

    on_nxt  = run && out_en && (is_auto || is_man);
    lvl_nxt = (cnt_nxt < cmp_nxt) ? start_high : !start_high;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      act_cmp    <= '0;
      pwm_out    <= 1'b0;
      pwm_active <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      act_cmp    <= cmp_nxt;
      pwm_out    <= on_nxt && lvl_nxt;
      pwm_active <= on_nxt;
    end
  end
endmodule

// File: rtl/cfpt_timer.sv
module cfpt_timer
  import cfpt_pkg::*;
#(
  parameter int W      = 32,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              tick_in,
  output logic [W-1:0]      cur_count,
  output logic              pwm_out,
  output logic              pwm_active,
  output logic              irq,
  output logic              fifo_full,
  output logic              fifo_empty
);
  ctrl_t        ctrl_q;
  logic [W-1:0] max_q, cmp_q, fifo_rdata;
  logic         step, wrap_now, fifo_pop;
  logic         wr_ctrl, wr_max, wr_cmp, wr_push, wr_cmd;
  logic         cmd_flush, cmd_clr;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_max    = wr_en && (wr_addr == A_MAX);
  assign wr_cmp    = wr_en && (wr_addr == A_CMP);
  assign wr_push   = wr_en && (wr_addr == A_PUSH);
  assign wr_cmd    = wr_en && (wr_addr == A_CMD);
  assign cmd_flush = wr_cmd && wr_data[0];
  assign cmd_clr   = wr_cmd && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      max_q  <= {{(W-1){1'b1}}, 1'b0};
      cmp_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
      if (wr_max)  max_q  <= {wr_data[W-1:1], 1'b0};
      if (wr_cmp)  cmp_q  <= wr_data;
      if (wrap_now)     irq <= 1'b1;
      else if (cmd_clr) irq <= 1'b0;
    end
  end

  cfpt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (!ctrl_q.run),
    .tick (tick_in),
    .sel  (ctrl_q.div_sel),
    .step (step)
  );

  cfpt_cmp_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (cmd_flush),
    .push  (wr_push),
    .wdata (wr_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  cfpt_wave #(.W(W)) u_wave (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl_q.run),
    .step       (step),
    .mode       (ctrl_q.mode),
    .start_high (ctrl_q.start_high),
    .out_en     (ctrl_q.out_en),
    .max_cnt    (max_q),
    .man_cmp    (cmp_q),
    .fifo_rdata (fifo_rdata),
    .fifo_empty (fifo_empty),
    .wrap_now   (wrap_now),
    .fifo_pop   (fifo_pop),
    .cnt        (cur_count),
    .pwm_out    (pwm_out),
    .pwm_active (pwm_active)
  );
endmodule

// File: rtl/cfpt_checker.sv
module cfpt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         push,
  input logic         pop,
  input logic         flush,
  input logic         clr,
  input logic [W-1:0] cur_count,
  input logic         pwm_out,
  input logic         pwm_active,
  input logic         irq,
  input logic         fifo_full,
  input logic         fifo_empty
);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  assert_full_drops_push_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && push && !pop && !flush) |=> fifo_full);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> fifo_empty);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    !pwm_active |-> !pwm_out);

  assert_stop_holds_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cur_count == '0));
endmodule

bind cfpt_timer cfpt_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (ctrl_q.run),
  .push       (wr_push),
  .pop        (fifo_pop),
  .flush      (cmd_flush),
  .clr        (cmd_clr),
  .cur_count  (cur_count),
  .pwm_out    (pwm_out),
  .pwm_active (pwm_active),
  .irq        (irq),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/cfpt_timer_tb.sv
module cfpt_timer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick_in = 1;
  logic [31:0] cur_count;
  logic        pwm_out, pwm_active, irq, fifo_full, fifo_empty;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  cfpt_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_in(tick_in), .cur_count(cur_count), .pwm_out(pwm_out),
    .pwm_active(pwm_active), .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] mx;
    logic [31:0] cmp;
    logic        pol;
  } vec_t;

  // max as written (bit 0 is dropped by the block), compare, start-high
  localparam vec_t VEC [0:5] = '{
    '{32'd9,  32'd3,  1'b1},
    '{32'd8,  32'd0,  1'b1},
    '{32'd6,  32'd7,  1'b0},
    '{32'd10, 32'd5,  1'b0},
    '{32'd12, 32'd12, 1'b1},
    '{32'd4,  32'd2,  1'b1}
  };

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [31:0] ctl(input bit run, input logic [1:0] mode,
                                      input bit pol, input bit en, input logic [2:0] dv);
    return {24'd0, dv, en, pol, mode, run};
  endfunction

  task automatic wait_count(input logic [31:0] v);
    while (cur_count != v) @(negedge clk);
  endtask

  task automatic period_highs(input int p, output int highs);
    highs = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cur_count == 0 && !pwm_out && !pwm_active && !irq, "R1 outputs", cur_count, 0);
    chk(fifo_empty && !fifo_full, "R1 fifo flags", {fifo_full, fifo_empty}, 1);

    // vector table: manual PWM, R2 and R4
    for (int v = 0; v < 6; v++) begin
      logic [31:0] m;
      int p, c, exp_h, highs, bad, mseen;
      m = VEC[v].mx & ~32'd1;
      p = int'(m) + 1;
      c = (VEC[v].cmp > m) ? p : int'(VEC[v].cmp);
      exp_h = VEC[v].pol ? c : p - c;
      wr(3'd0, 32'd0);
      wr(3'd1, VEC[v].mx);
      wr(3'd2, VEC[v].cmp);
      wr(3'd0, ctl(1, 2'd2, VEC[v].pol, 1, 3'd0));
      wait_count(m);
      highs = 0; bad = 0; mseen = 0;
      for (int i = 0; i < p; i++) begin
        @(negedge clk);
        if (pwm_out) highs++;
        if (int'(cur_count) > mseen) mseen = int'(cur_count);
        if (pwm_out != ((cur_count < VEC[v].cmp) ? VEC[v].pol : !VEC[v].pol)) bad++;
      end
      chk(highs == exp_h, "R4 high cycles per period", highs, exp_h);
      chk(bad == 0, "R4 level versus count", bad, 0);
      chk(mseen == int'(m), "R2 top count with bit 0 cleared", mseen, m);
      @(negedge clk);
      chk(cur_count == 0, "R2 wrap to zero", cur_count, 0);
      chk(pwm_active, "R9 active while enabled", pwm_active, 1);
    end

    // R9 output enable off: no PWM
    begin
      int highs;
      wr(3'd0, 32'd0);
      wr(3'd1, 32'd8);
      wr(3'd2, 32'd4);
      wr(3'd0, ctl(1, 2'd2, 1, 0, 3'd0));
      wait_count(8);
      period_highs(9, highs);
      chk(highs == 0 && !pwm_active, "R9 gated output", highs, 0);
    end

    // R10 stopped counter
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(cur_count == 0 && !pwm_out, "R10 stopped holds zero", cur_count, 0);

    // R3 divider codes
    begin
      logic [2:0] codes [6] = '{3'd0, 3'd4, 3'd5, 3'd6, 3'd7, 3'd2};
      int         divs  [6] = '{1, 2, 4, 8, 40, 1};
      wr(3'd1, 32'd1000);
      for (int k = 0; k < 6; k++) begin
        int n;
        wr(3'd0, 32'd0);
        wr(3'd0, ctl(1, 2'd0, 0, 0, codes[k]));
        wait_count(1);
        n = 0;
        do begin @(negedge clk); n++; end while (cur_count == 1);
        chk(n == divs[k], "R3 ticks per step", n, divs[k]);
      end
      tick_in = 0;
      begin
        logic [31:0] held;
        held = cur_count;
        repeat (50) @(negedge clk);
        chk(cur_count == held, "R3 no tick holds count", cur_count, held);
      end
      tick_in = 1;
    end

    // R8 period interrupt in free-run, R9 free-run output low
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd2);
    @(negedge clk);
    chk(!irq, "R8 cleared", irq, 0);
    wr(3'd1, 32'd4);
    wr(3'd0, ctl(1, 2'd0, 1, 1, 3'd0));
    wait_count(4);
    chk(!irq, "R8 not set before wrap", irq, 0);
    @(negedge clk);
    chk(irq && cur_count == 0, "R8 set at wrap", irq, 1);
    chk(!pwm_out && !pwm_active, "R9 free-run output low", pwm_out, 0);
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(irq, "R8 sticky after stop", irq, 1);
    wr(3'd4, 32'd2);
    chk(!irq, "R8 write-one clear", irq, 1'b0);

    // R6 / R5 auto mode: fill, drop a push, then run five periods
    begin
      int exp_h [5] = '{2, 4, 6, 8, 8};
      wr(3'd2, 32'd1);
      wr(3'd4, 32'd1);
      chk(fifo_empty && !fifo_full, "R7 flush when idle", fifo_empty, 1);
      wr(3'd3, 32'd2);
      wr(3'd3, 32'd4);
      wr(3'd3, 32'd6);
      chk(!fifo_full && !fifo_empty, "R6 partial level", fifo_full, 0);
      wr(3'd3, 32'd8);
      chk(fifo_full && !fifo_empty, "R6 full at four", fifo_full, 1);
      wr(3'd3, 32'd3);
      chk(fifo_full, "R6 still full after extra push", fifo_full, 1);
      wr(3'd1, 32'd10);
      wr(3'd0, ctl(1, 2'd1, 1, 1, 3'd0));
      for (int k = 0; k < 5; k++) begin
        int highs;
        wait_count(10);
        period_highs(11, highs);
        chk(highs == exp_h[k], "R5 popped duty per period", highs, exp_h[k]);
      end
      chk(fifo_empty && !fifo_full, "R6 empty after four pops", fifo_empty, 1);
    end

    // R7 flush of a full FIFO
    wr(3'd0, 32'd0);
    for (int k = 0; k < 4; k++) wr(3'd3, 32'(k + 1));
    chk(fifo_full, "R7 prefill", fifo_full, 1);
    wr(3'd4, 32'd1);
    chk(fifo_empty && !fifo_full, "R7 flush empties", fifo_empty, 1);

    report();
  end
endmodule